// File: doc/BRIEF.md
# Phase-Split Shared Memory Arbiter

This block lets a processor port and a display fetch port share one 4 KB memory. Ownership is not decided by requests. A free-running divider inside the block produces a timing bit, and ownership follows that bit. While the bit is low, the processor owns the single address, data and write-enable path. While it is high, the display address generator owns the path, and the word it addresses is read out.

A processor request that arrives during the display half is not lost. It is held with ready deasserted until the bit falls, and it then completes in one cycle. The display side receives a registered word captured at the close of every high half. That word stays steady for the rest of the period, so a downstream pixel pipeline can latch it without timing hazards.

The array is built as two 2 KB banks. The top address bit picks which bank is enabled.

Top module: `shared_mem_arbiter`

## Requirements
- R1: While rst_ni is low, phase_o, cpu_ready_o, cpu_rdata_o and vid_rdata_o are all 0.
- R2: After reset is released, phase_o is low for two clock cycles, then high for two, and repeats this 4-cycle period.
- R3: cpu_ready_o equals cpu_req_i while phase_o is low, and is 0 while phase_o is high.
- R4: A write (cpu_req_i=1, cpu_we_i=1) updates the memory only at a clock edge ending a cycle in which phase_o is low. A write presented during the high half leaves the stored word unchanged until the phase falls.
- R5: A read that completes (cpu_req_i=1, cpu_we_i=0, cpu_ready_o=1) puts the addressed byte on cpu_rdata_o from the next cycle on. cpu_rdata_o changes at no other time, including after writes.
- R6: At the edge ending the second high cycle, vid_rdata_o loads the byte at vid_addr_i. It then holds that value for the following four cycles.
- R7: Bit 11 of the address selects one of two 2 KB banks, so addresses that differ only in bit 11 store independent bytes.
- R8: vid_addr_i has no effect on any output while phase_o is low, and the display port never writes.
- R9: A request held since the high half completes on the first low cycle, so it waits 2 cycles if raised in the first high cycle and 1 cycle if raised in the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor access request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 12 | Processor byte address |
| cpu_wdata_i | input | 8 | Processor write byte |
| cpu_ready_o | output | 1 | Access completes at the next edge |
| cpu_rdata_o | output | 8 | Registered processor read byte |
| vid_addr_i | input | 12 | Display fetch address |
| vid_rdata_o | output | 8 | Registered display byte, reloaded once per period |
| phase_o | output | 1 | Ownership bit: 0 = processor, 1 = display |

## Verification
The hardest case to reach is a write that collides with a display fetch of the same address. The write must be seen to wait, and the display word must be checked to still show the old byte. The bench reaches this by tracking the period from reset release. It raises a write in the first high cycle with the display address pointing at that byte. It then checks that ready stays low for exactly two cycles and that the capture at the end of the high half returns the previous value. After the write completes, it checks that the next capture returns the new one.

// File: rtl/shm_arb_pkg.sv
package shm_arb_pkg;
  typedef enum logic {
    OWN_CPU = 1'b0,
    OWN_VID = 1'b1
  } owner_e;
endpackage

// File: rtl/shm_phase_gen.sv
module shm_phase_gen #(
  parameter int DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o,
  output logic last_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign phase_o = cnt_q[DIV_W-1];
  // final cycle of the high half
  assign last_o  = &cnt_q;
endmodule

// File: rtl/shm_bank_array.sv
module shm_bank_array #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 2
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int SEL_W   = $clog2(NUM_BANKS);
  localparam int BANK_AW = ADDR_W - SEL_W;
  localparam int DEPTH   = 1 << BANK_AW;

  logic [SEL_W-1:0]   sel;
  logic [BANK_AW-1:0] addr_lo;
  logic [DATA_W-1:0]  bank_rd [NUM_BANKS];

  assign sel     = addr_i[ADDR_W-1 -: SEL_W];
  assign addr_lo = addr_i[BANK_AW-1:0];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic              bank_en;

    assign bank_en = (sel == SEL_W'(g));

    always_ff @(posedge clk_i) begin
      if (we_i && bank_en) mem[addr_lo] <= wdata_i;
    end

    assign bank_rd[g] = mem[addr_lo];
  end

  assign rdata_o = bank_rd[sel];
endmodule

// File: rtl/shared_mem_arbiter.sv
module shared_mem_arbiter
  import shm_arb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int DIV_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic [ADDR_W-1:0] vid_addr_i,
  output logic [DATA_W-1:0] vid_rdata_o,
  output logic              phase_o
);
  owner_e            owner;
  logic              phase;
  logic              last_high;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic              cpu_rd_fire;
  logic [DATA_W-1:0] cpu_rdata_q;
  logic [DATA_W-1:0] vid_rdata_q;

  shm_phase_gen #(.DIV_W(DIV_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase),
    .last_o (last_high)
  );

  assign owner       = phase ? OWN_VID : OWN_CPU;
  assign cpu_ready_o = cpu_req_i && (owner == OWN_CPU);
  assign mem_we      = cpu_ready_o && cpu_we_i;
  assign cpu_rd_fire = cpu_ready_o && !cpu_we_i;
  assign mem_addr    = (owner == OWN_VID) ? vid_addr_i : cpu_addr_i;

  shm_bank_array #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_BANKS(NUM_BANKS)
  ) u_mem (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .addr_i (mem_addr),
    .wdata_i(cpu_wdata_i),
    .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rdata_q <= '0;
      vid_rdata_q <= '0;
    end else begin
      if (cpu_rd_fire) cpu_rdata_q <= mem_rdata;
      if (last_high)   vid_rdata_q <= mem_rdata;
    end
  end

  assign cpu_rdata_o = cpu_rdata_q;
  assign vid_rdata_o = vid_rdata_q;
  assign phase_o     = phase;
endmodule

// File: rtl/shared_mem_arbiter_chk.sv
module shared_mem_arbiter_chk #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic              cpu_ready_o,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic [DATA_W-1:0] vid_rdata_o,
  input logic              phase_o,
  input logic              mem_we
);
  logic [DIV_W-1:0] ref_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_cnt <= '0;
    else         ref_cnt <= ref_cnt + 1'b1;
  end

  p_phase_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == ref_cnt[DIV_W-1]);

  p_no_ready_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o |-> !cpu_ready_o);

  p_ready_low_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_o && cpu_req_i) |-> cpu_ready_o);

  p_write_low_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (!phase_o && cpu_req_i && cpu_we_i));

  p_cpu_rdata_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cpu_rdata_o) |-> $past(cpu_ready_o && !cpu_we_i));

  p_vid_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vid_rdata_o) |-> $past(phase_o));
endmodule

bind shared_mem_arbiter shared_mem_arbiter_chk #(
  .DATA_W(DATA_W),
  .DIV_W (DIV_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_req_i  (cpu_req_i),
  .cpu_we_i   (cpu_we_i),
  .cpu_ready_o(cpu_ready_o),
  .cpu_rdata_o(cpu_rdata_o),
  .vid_rdata_o(vid_rdata_o),
  .phase_o    (phase_o),
  .mem_we     (mem_we)
);

// File: tb/tb_shared_mem_arbiter.sv
`timescale 1ns/1ps
module tb_shared_mem_arbiter;
  localparam int NV = 8;
  // {addr[11:0], data[7:0]}
  localparam logic [19:0] VEC [NV] = '{
    {12'h000, 8'h5A}, {12'h800, 8'hFE}, {12'h7FF, 8'h01}, {12'hFFF, 8'hC3},
    {12'h123, 8'h77}, {12'h923, 8'h88}, {12'h456, 8'h00}, {12'hABC, 8'h99}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [11:0] cpu_addr = '0, vid_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ready, phase;
  logic [7:0]  cpu_rdata, vid_rdata;
  logic [1:0]  bcnt;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= 0; else bcnt <= bcnt + 1;

  shared_mem_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .vid_addr_i(vid_addr), .vid_rdata_o(vid_rdata), .phase_o(phase)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cpu_op(input bit we, input logic [11:0] a, input logic [7:0] d,
                        output int waits);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; waits = 0;
    #1;
    while (!cpu_ready && waits < 5) begin
      chk(bcnt[1] == 1'b1, "R3 ready low outside video half", int'(bcnt), 2);
      tick(); waits++; #1;
    end
    chk(cpu_ready && bcnt[1] == 1'b0, "R3 ready in processor half", int'(cpu_ready), 1);
    tick();
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic vid_read(input logic [11:0] a, input logic [7:0] exp);
    vid_addr = a;
    while (bcnt != 2'd3) tick();
    tick();
    chk(vid_rdata == exp, "R6 display capture", int'(vid_rdata), int'(exp));
    for (int k = 0; k < 4; k++) begin
      vid_addr = ~a; #1;
      chk(vid_rdata == exp, "R6 R8 display word held", int'(vid_rdata), int'(exp));
      if (k < 3) tick();
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int w;
    logic [7:0] hold;
    repeat (3) @(negedge clk);
    chk(phase == 0 && cpu_ready == 0, "R1 reset control", int'({phase, cpu_ready}), 0);
    chk(cpu_rdata == 0 && vid_rdata == 0, "R1 reset data", int'({cpu_rdata, vid_rdata}), 0);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      chk(phase == bcnt[1], "R2 phase period", int'(phase), int'(bcnt[1]));
      tick();
    end

    for (int i = 0; i < NV; i++) cpu_op(1'b1, VEC[i][19:8], VEC[i][7:0], w);
    for (int i = 0; i < NV; i++) begin
      cpu_op(1'b0, VEC[i][19:8], 8'h00, w);
      chk(cpu_rdata == VEC[i][7:0], "R5 R7 processor read", int'(cpu_rdata), int'(VEC[i][7:0]));
    end
    for (int i = 0; i < NV; i++) vid_read(VEC[i][19:8], VEC[i][7:0]);

    // R5: rdata unchanged by idle cycles and writes
    hold = cpu_rdata;
    cpu_op(1'b1, 12'h456, 8'h42, w);
    repeat (3) tick();
    chk(cpu_rdata == hold, "R5 rdata held after write", int'(cpu_rdata), int'(hold));

    // R4 R9: write raised in first high cycle, display fetching the same byte
    cpu_op(1'b1, 12'h345, 8'h11, w);
    while (bcnt != 2'd2) tick();
    vid_addr = 12'h345;
    cpu_req = 1; cpu_we = 1; cpu_addr = 12'h345; cpu_wdata = 8'h3C; #1;
    chk(!cpu_ready, "R3 R9 held in first high cycle", int'(cpu_ready), 0);
    tick(); #1;
    chk(!cpu_ready, "R3 R9 held in second high cycle", int'(cpu_ready), 0);
    tick(); #1;
    chk(vid_rdata == 8'h11, "R4 write not done in video half", int'(vid_rdata), 8'h11);
    chk(cpu_ready, "R9 completes on first low cycle", int'(cpu_ready), 1);
    tick();
    cpu_req = 0; cpu_we = 0;
    vid_read(12'h345, 8'h3C);

    // R9: wait counts from each high cycle
    while (bcnt != 2'd2) tick();
    cpu_op(1'b0, 12'h345, 8'h00, w);
    chk(w == 2, "R9 wait from first high cycle", w, 2);
    chk(cpu_rdata == 8'h3C, "R4 R5 held write stored", int'(cpu_rdata), 8'h3C);
    while (bcnt != 2'd3) tick();
    cpu_op(1'b0, 12'hABC, 8'h00, w);
    chk(w == 1, "R9 wait from second high cycle", w, 1);
    chk(cpu_rdata == 8'h99, "R9 held read data", int'(cpu_rdata), 8'h99);
    while (bcnt != 2'd0) tick();
    cpu_op(1'b0, 12'h800, 8'h00, w);
    chk(w == 0, "R3 no wait in low half", w, 0);
    chk(cpu_rdata == 8'hFE, "R7 upper bank", int'(cpu_rdata), 8'hFE);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule